// File: doc/BRIEF.md
# PCI Configuration Header Responder

This block holds the 256-byte type-0 configuration header of a small serial controller and answers dword configuration accesses from the fabric. A request names a dword index, a read or write direction, four byte enables and write data. Reads return the whole aligned dword. Each write is filtered according to the register it lands on. Identity, class and command/status values are fixed. Base address registers accept a programmed base or an all-ones sizing probe. The interrupt line byte is the only plain read/write storage. Everything else in the header either reads zero or keeps its fixed value.

The parameter `NUM_PORTS` selects a one-port or a two-port controller. Each port owns an 8-byte I/O window. The second base address register exists only when two ports are configured.

Requests use a valid/ready handshake. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Only a read produces a response: `rsp_valid` and `rsp_rdata` appear in the cycle after the read is accepted. They hold, unchanged, until the edge where `rsp_ready` is high. `req_ready` is low only while a response is waiting and `rsp_ready` is low. This lets a new request be taken in the same cycle the old response drains. A write completes when it is accepted.

Top module: `pci_cfg_responder`

## Requirements
- R1: After reset, dword 0 (byte offset 0x00, vendor/device identity) and dword 11 (offset 0x2C, subsystem identity) both read 0x32534348.
- R2: Dword 1 (offset 0x04) reads 0x02000001: command 0x0001 in bits 15:0 and status 0x0200 in bits 31:16. Writes to it have no effect.
- R3: Dword 2 (offset 0x08) reads 0x07000210. Bits 7:0 are the revision 0x10, bits 15:8 the programming interface 0x02, bits 23:16 the subclass 0x00, and bits 31:24 the base class 0x07.
- R4: After reset, BAR0 (dword 4, offset 0x10) reads 0x00000001. BAR1 (dword 5, offset 0x14) also reads 0x00000001 when NUM_PORTS is 2, and reads 0 when NUM_PORTS is 1.
- R5: A write to an implemented BAR is first merged with the old value under its byte enables. If the merged value is 0xFFFFFFFF, the BAR stores the window size mask 0xFFFFFFF8, so it reads 0xFFFFFFF9 with its type bits kept.
- R6: Any other write to an implemented BAR stores the byte-enable-merged value in bits 31:2. Bits 1:0 always keep their previous value.
- R7: BAR1 with one port, and BAR2 to BAR4 (dwords 6 to 8), read 0 after any write.
- R8: Dword 15 (offset 0x3C) carries the interrupt line in bits 7:0, which is written when byte enable 0 is set. It carries the interrupt pin 0x01 in bits 15:8, which ignores writes, and 0 in bits 31:16. Dword 13 (offset 0x34, capability pointer) reads 0.
- R9: Dwords not named above read 0, and writes to them change nothing.
- R10: After reset, rsp_valid is 0 and req_ready is 1. A read accepted at one edge gives rsp_valid=1 with its data after that edge. While rsp_ready is 0, the response stays valid with stable data and req_ready is 0. A write produces no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dword | input | 6 | Dword index into the 256-byte header |
| req_be | input | 4 | Byte enables for a write, bit n covers bits 8n+7:8n |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes the read data |
| rsp_rdata | output | 32 | Read data of the accepted read |

## Verification
Two things can fall in the same cycle: a write being accepted while an earlier read response drains, and a read accepted in the cycle right after a write to the same register. The bench stalls a read response with rsp_ready low while a write to the interrupt line waits. It checks that the held data does not move and that the request is not taken. It then releases both in one edge. It also issues a BAR write and a read of that BAR back to back. A behavioural model updated at every edge is compared with rsp_valid and rsp_rdata on every clock. This confirms that the drained response carries the old value and that the following read sees the new one.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;

  localparam logic [31:0] ID_DWORD     = 32'h3253_4348;
  localparam logic [15:0] CMD_INIT     = 16'h0001;
  localparam logic [15:0] STAT_INIT    = 16'h0200;
  localparam logic [7:0]  REV_ID       = 8'h10;
  localparam logic [7:0]  PROG_IF      = 8'h02;
  localparam logic [7:0]  SUB_CLASS    = 8'h00;
  localparam logic [7:0]  BASE_CLASS   = 8'h07;
  localparam logic [7:0]  INTR_PIN_A   = 8'h01;
  localparam logic [31:0] BAR_IO_INIT  = 32'h0000_0001;

  // dword indices whose position is fixed by the header layout
  localparam int IDX_IDENT   = 0;
  localparam int IDX_CMDSTAT = 1;
  localparam int IDX_CLASS   = 2;
  localparam int IDX_BAR0    = 4;
  localparam int IDX_SUBSYS  = 11;
  localparam int IDX_CAPPTR  = 13;
  localparam int IDX_INTR    = 15;

  localparam int MAX_IO_BARS = 2;

  function automatic logic [31:0] merge_bytes(input logic [31:0] old_v,
                                              input logic [31:0] new_v,
                                              input logic [3:0]  be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      r[8*b +: 8] = be[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
    return r;
  endfunction

endpackage

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot
  import pcicfg_pkg::*;
#(
  parameter int WIN_BYTES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] bar_q
);

  localparam logic [31:0] SIZE_MASK = ~(32'(WIN_BYTES) - 32'd1);

  logic [31:0] merged;
  logic [31:0] next_v;
  logic        probe;

  always_comb begin
    merged = merge_bytes(bar_q, wdata, be);
    probe  = (merged == 32'hFFFF_FFFF);
    next_v = probe ? SIZE_MASK : merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bar_q <= BAR_IO_INIT;
    else if (wr_en)
      bar_q <= {next_v[31:2], bar_q[1:0]};
  end

  AST_TYPE_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(bar_q[1:0])); // R6

  AST_SIZE_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && probe |=> bar_q[31:2] == SIZE_MASK[31:2]); // R5

endmodule

// File: rtl/cfg_rsp_stage.sv
module cfg_rsp_stage #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          rsp_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          free
);

  assign free = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_data  <= load_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)); // R10

  AST_NO_LOAD_WHEN_STUCK: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !load); // R10

endmodule

// File: rtl/pci_cfg_responder.sv
module pci_cfg_responder
  import pcicfg_pkg::*;
#(
  parameter int NUM_PORTS     = 2,
  parameter int BAR_WIN_BYTES = 8,
  parameter int DWORD_IDX_W   = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [DWORD_IDX_W-1:0] req_dword,
  input  logic [3:0]             req_be,
  input  logic [31:0]            req_wdata,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [31:0]            rsp_rdata
);

  localparam logic [DWORD_IDX_W-1:0] A_IDENT   = DWORD_IDX_W'(IDX_IDENT);
  localparam logic [DWORD_IDX_W-1:0] A_CMDSTAT = DWORD_IDX_W'(IDX_CMDSTAT);
  localparam logic [DWORD_IDX_W-1:0] A_CLASS   = DWORD_IDX_W'(IDX_CLASS);
  localparam logic [DWORD_IDX_W-1:0] A_BAR0    = DWORD_IDX_W'(IDX_BAR0);
  localparam logic [DWORD_IDX_W-1:0] A_BAR1    = DWORD_IDX_W'(IDX_BAR0 + 1);
  localparam logic [DWORD_IDX_W-1:0] A_SUBSYS  = DWORD_IDX_W'(IDX_SUBSYS);
  localparam logic [DWORD_IDX_W-1:0] A_INTR    = DWORD_IDX_W'(IDX_INTR);

  logic        accept;
  logic        acc_wr;
  logic        acc_rd;
  logic [31:0] bar_q [MAX_IO_BARS];
  logic [7:0]  intr_line_q;
  logic [31:0] rd_word;
  logic        stage_free;

  assign req_ready = stage_free;
  assign accept    = req_valid && req_ready;
  assign acc_wr    = accept && req_write;
  assign acc_rd    = accept && !req_write;

  for (genvar p = 0; p < MAX_IO_BARS; p++) begin : g_bar
    if (p < NUM_PORTS) begin : g_live
      cfg_bar_slot #(.WIN_BYTES(BAR_WIN_BYTES)) u_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (acc_wr && (req_dword == DWORD_IDX_W'(IDX_BAR0 + p))),
        .be    (req_be),
        .wdata (req_wdata),
        .bar_q (bar_q[p])
      );
    end else begin : g_absent
      assign bar_q[p] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      intr_line_q <= 8'h00;
    else if (acc_wr && (req_dword == A_INTR) && req_be[0])
      intr_line_q <= req_wdata[7:0];
  end

  always_comb begin
    case (req_dword)
      A_IDENT, A_SUBSYS: rd_word = ID_DWORD;
      A_CMDSTAT:         rd_word = {STAT_INIT, CMD_INIT};
      A_CLASS:           rd_word = {BASE_CLASS, SUB_CLASS, PROG_IF, REV_ID};
      A_BAR0:            rd_word = bar_q[0];
      A_BAR1:            rd_word = bar_q[1];
      A_INTR:            rd_word = {16'h0000, INTR_PIN_A, intr_line_q};
      default:           rd_word = 32'h0000_0000;
    endcase
  end

  cfg_rsp_stage #(.DW(32)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (acc_rd),
    .load_data (rd_word),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_rdata),
    .free      (stage_free)
  );

  AST_IDENT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd && (req_dword == A_IDENT) |=> rsp_rdata == 32'h3253_4348); // R1

  AST_CMDSTAT_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd && (req_dword == A_CMDSTAT) |=> rsp_rdata == 32'h0200_0001); // R2

  AST_PIN_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd && (req_dword == A_INTR) |=> rsp_rdata[31:8] == 24'h00_0001); // R8

  AST_WRITE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr && !rsp_valid |=> !rsp_valid); // R10

endmodule

// File: tb/pci_cfg_responder_bench.sv
module pci_cfg_responder_bench;

  localparam int NP = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [5:0]  req_dword = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;

  int    checks = 0;
  int    errors = 0;
  string phase = "R10";
  bit    done = 1'b0;

  // behavioural reference state
  logic [31:0] m_bar [2];
  logic [7:0]  m_line;
  logic        m_valid;
  logic [31:0] m_data;

  always #10 clk = ~clk;

  pci_cfg_responder #(.NUM_PORTS(NP)) u_pci_cfg_responder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_dword(req_dword), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata)
  );

  function automatic logic [31:0] ref_read(input int idx);
    if (idx == 0 || idx == 11) return 32'h3253_4348;
    if (idx == 1)  return 32'h0200_0001;
    if (idx == 2)  return 32'h0700_0210;
    if (idx == 4)  return m_bar[0];
    if (idx == 5)  return (NP == 2) ? m_bar[1] : 32'h0;
    if (idx == 15) return {16'h0, 8'h01, m_line};
    return 32'h0;
  endfunction

  task automatic ref_write(input int idx, input logic [3:0] be, input logic [31:0] wd);
    logic [31:0] m;
    int b;
    if (idx == 4 || (idx == 5 && NP == 2)) begin
      b = idx - 4;
      m = m_bar[b];
      for (int k = 0; k < 4; k++) if (be[k]) m[8*k +: 8] = wd[8*k +: 8];
      if (m == 32'hFFFF_FFFF) m = 32'hFFFF_FFF8;
      m_bar[b] = {m[31:2], m_bar[b][1:0]};
    end
    if (idx == 15 && be[0]) m_line = wd[7:0];
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_bar[0] = 32'h1; m_bar[1] = 32'h1; m_line = 8'h0;
      m_valid = 1'b0; m_data = 32'h0;
    end else begin
      logic take;
      take = req_valid && (!m_valid || rsp_ready);
      if (take && !req_write) begin
        m_valid = 1'b1;
        m_data  = ref_read(int'(req_dword));
      end else if (rsp_ready) begin
        m_valid = 1'b0;
      end
      if (take && req_write) ref_write(int'(req_dword), req_be, req_wdata);
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (rsp_valid !== m_valid || (m_valid && rsp_rdata !== m_data)) begin
        errors++;
        $display("FAIL %s model: valid=%0b data=%h expected valid=%0b data=%h",
                 phase, rsp_valid, rsp_rdata, m_valid, m_data);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic [5:0] a, input logic [3:0] be,
                       input logic [31:0] d);
    req_valid = 1'b1; req_write = wr; req_dword = a; req_be = be; req_wdata = d;
    @(negedge clk);
  endtask

  task automatic idle();
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    phase = tag;
    issue(1'b0, a, 4'h0, 32'h0);
    chk(tag, {31'h0, rsp_valid}, 32'h1);
    chk(tag, rsp_rdata, exp);
    idle();
  endtask

  task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d,
                    input string tag);
    phase = tag;
    issue(1'b1, a, be, d);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", {30'h0, rsp_valid, req_ready}, 32'h1);

    rd(6'd0,  32'h3253_4348, "R1");
    rd(6'd11, 32'h3253_4348, "R1");
    rd(6'd1,  32'h0200_0001, "R2");
    rd(6'd2,  32'h0700_0210, "R3");
    rd(6'd4,  32'h0000_0001, "R4");
    rd(6'd5,  32'h0000_0001, "R4");

    wr(6'd1, 4'hF, 32'hFFFF_FFFF, "R2");
    rd(6'd1, 32'h0200_0001, "R2");

    wr(6'd4, 4'hF, 32'hFFFF_FFFF, "R5");
    rd(6'd4, 32'hFFFF_FFF9, "R5");
    wr(6'd4, 4'hF, 32'h0000_C000, "R6");
    rd(6'd4, 32'h0000_C001, "R6");
    wr(6'd4, 4'hF, 32'h1234_5672, "R6");
    rd(6'd4, 32'h1234_5671, "R6");
    wr(6'd4, 4'h4, 32'hAABB_CCDD, "R6");
    rd(6'd4, 32'h12BB_5671, "R6");
    wr(6'd5, 4'h3, 32'hFFFF_FFFF, "R6");
    rd(6'd5, 32'h0000_FFFD, "R6");
    wr(6'd5, 4'hC, 32'hFFFF_FFFF, "R6");
    rd(6'd5, 32'hFFFF_FFFD, "R6");

    for (int i = 6; i <= 8; i++) begin
      wr(6'(i), 4'hF, 32'h1234_5678, "R7");
      rd(6'(i), 32'h0, "R7");
    end

    wr(6'd15, 4'h1, 32'h0000_AB5A, "R8");
    rd(6'd15, 32'h0000_015A, "R8");
    wr(6'd15, 4'hE, 32'hFFFF_FFFF, "R8");
    rd(6'd15, 32'h0000_015A, "R8");
    rd(6'd13, 32'h0, "R8");

    wr(6'd16, 4'hF, 32'hDEAD_BEEF, "R9");
    rd(6'd16, 32'h0, "R9");
    rd(6'd63, 32'h0, "R9");

    // stalled response with a write waiting behind it
    phase = "R10";
    rsp_ready = 1'b0;
    issue(1'b0, 6'd4, 4'h0, 32'h0);
    chk("R10", rsp_rdata, 32'h12BB_5671);
    issue(1'b1, 6'd15, 4'h1, 32'h0000_0077);
    for (int c = 0; c < 2; c++) begin
      chk("R10", {30'h0, rsp_valid, req_ready}, 32'h2);
      chk("R10", rsp_rdata, 32'h12BB_5671);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R10", {31'h0, rsp_valid}, 32'h0);
    idle();
    rd(6'd15, 32'h0000_0177, "R10");

    // write followed at once by a read of the same BAR
    phase = "R6";
    issue(1'b1, 6'd4, 4'hF, 32'hAAAA_0000);
    issue(1'b0, 6'd4, 4'h0, 32'h0);
    chk("R6", rsp_rdata, 32'hAAAA_0001);
    idle();
    idle();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule